// File: doc/BRIEF.md
# Drift-Compensated NCO Increment Scaler

This block drives a phase-accumulator NCO whose clock is a free-running local oscillator with unknown offset and slow drift. A stable reference is available as a single-cycle tick that has already been synchronised into the local clock domain. The block counts local-clock cycles over a window of N reference ticks (N = 2^LOG2N). It multiplies that count by a 64-bit nominal phase increment and shifts the product right by a fixed amount, NORM_SHIFT, which equals log2 of the ideal count per window. The result is a corrected increment. No division of one frequency count by another is ever performed. A longer window gives a finer ratio. In a real system, N is chosen so that a new increment arrives roughly every 1.6 ms.

The corrected increment is presented together with a one-cycle valid strobe. The accumulator starts to use it on the cycle after the strobe. Until the first window after reset has closed, the accumulator advances by the nominal increment taken straight from the input. The accumulator itself is loaded with an initial phase word while reset is held. It then adds the active increment on every local-clock cycle and wraps modulo 2^64.

Top module: `nco_drift_scaler`

## Requirements
- R1: While `rst` is high, `phaseWord` equals `initPhase`, `corrValid` is 0 and `corrInc` is 0.
- R2: On every clock edge out of reset, `phaseWord` advances by the active increment, modulo 2^64.
- R3: Until the first `corrValid` pulse after reset, the active increment is the current value of `nominalInc`.
- R4: The count used for a window is the number of clock edges between the capture edge of the previous window-closing tick and the capture edge of this one. No edge is dropped at the boundary. The first window counts from the release of reset.
- R5: A window closes on every N-th cycle with `refTick` high, counted from reset (N = 2^LOG2N). Ticks at any other position in the count produce no `corrValid`.
- R6: `corrInc` equals bits [NORM_SHIFT+63:NORM_SHIFT] of the 128-bit product of the window count and `nominalInc`.
- R7: `corrValid` is a one-cycle pulse, high two cycles after the cycle in which the window-closing tick is high. `corrInc` changes only in that pulse cycle.
- R8: A new `corrInc` becomes the active increment starting with the cycle after its `corrValid` pulse. In the pulse cycle itself, the previous increment is still the one in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| refTick | input | 1 | One-cycle reference tick, already in the local domain |
| nominalInc | input | 64 | Nominal phase increment |
| initPhase | input | 64 | Phase word loaded during reset |
| corrInc | output | 64 | Corrected phase increment |
| corrValid | output | 1 | One-cycle strobe marking a new corrected increment |
| phaseWord | output | 64 | NCO accumulator value |

## Verification
The hardest situation to reach is the hand-over cycle. There, a fresh corrected value is already visible on `corrInc`, but the accumulator must still step by the old increment for one more cycle. The bench reaches it by tracking, on every cycle, which increment should have been applied and comparing the phase step against it. Irregular tick spacing gives unequal window lengths. A nominal increment of all ones forces truncation of the 128-bit product. A second reset then returns the block to its nominal-increment state and starts the accumulator near the top of its range.

// File: rtl/nco_drift_pkg.sv
`timescale 1ns/1ps
package nco_drift_pkg;
  // Strobes from the window control to the datapath
  typedef struct packed {
    logic capture;   // window closes this cycle: latch count, restart counter
    logic multiply;  // held count is stable: form scaled increment
  } strobeT;
endpackage

// File: rtl/nco_window_ctrl.sv
`timescale 1ns/1ps
module nco_window_ctrl
  import nco_drift_pkg::*;
#(
  parameter int LOG2N = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   refTick,
  output strobeT strb
);
  localparam logic [LOG2N-1:0] LAST_TICK = {LOG2N{1'b1}};

  logic [LOG2N-1:0] tickCnt;
  logic             captureNow;
  logic             multiplyQ;

  assign captureNow = refTick && (tickCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt   <= '0;
      multiplyQ <= 1'b0;
    end else begin
      if (refTick) tickCnt <= tickCnt + 1'b1;
      multiplyQ <= captureNow;
    end
  end

  assign strb.capture  = captureNow;
  assign strb.multiply = multiplyQ;

  // A window needs at least two ticks, so capture and multiply never coincide
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.capture, strb.multiply})); // R5
endmodule

// File: rtl/nco_scale_datapath.sv
`timescale 1ns/1ps
module nco_scale_datapath
  import nco_drift_pkg::*;
#(
  parameter int PHASE_W    = 64,
  parameter int CNT_W      = 32,
  parameter int NORM_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  strobeT             strb,
  input  logic [PHASE_W-1:0] nominalInc,
  input  logic [PHASE_W-1:0] initPhase,
  output logic [PHASE_W-1:0] corrInc,
  output logic               corrValid,
  output logic [PHASE_W-1:0] phaseWord
);
  localparam int PROD_W = 2 * PHASE_W;

  logic [CNT_W-1:0]   localCnt;
  logic [CNT_W-1:0]   heldCnt;
  logic [PROD_W-1:0]  prodFull;
  logic [PHASE_W-1:0] scaledInc;
  logic [PHASE_W-1:0] activeInc;
  logic [PHASE_W-1:0] incUsed;
  logic               haveCorr;

  // Window cycle counter: capture and restart at 1 in the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      localCnt <= '0;
      heldCnt  <= '0;
    end else if (strb.capture) begin
      heldCnt  <= localCnt;
      localCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else begin
      localCnt <= localCnt + 1'b1;
    end
  end

  // Ratio scaling: count times nominal, normalised by a fixed shift
  always_comb begin
    prodFull  = {{(PROD_W-CNT_W){1'b0}}, heldCnt} * {{PHASE_W{1'b0}}, nominalInc};
    scaledInc = PHASE_W'(prodFull >> NORM_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corrInc   <= '0;
      corrValid <= 1'b0;
      activeInc <= '0;
      haveCorr  <= 1'b0;
    end else begin
      corrValid <= strb.multiply;
      if (strb.multiply) corrInc <= scaledInc;
      if (corrValid) begin
        activeInc <= corrInc;
        haveCorr  <= 1'b1;
      end
    end
  end

  // Phase accumulator, wraps modulo 2^PHASE_W
  assign incUsed = haveCorr ? activeInc : nominalInc;

  always_ff @(posedge clk) begin
    if (rst) phaseWord <= initPhase;
    else     phaseWord <= phaseWord + incUsed;
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strb.capture |-> (localCnt != '0)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    corrValid |=> !corrValid); // R7
  AST_CORR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strb.multiply |=> $stable(corrInc)); // R7
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !corrValid |=> $stable(activeInc)); // R8
endmodule

// File: rtl/nco_drift_scaler.sv
`timescale 1ns/1ps
module nco_drift_scaler
  import nco_drift_pkg::*;
#(
  parameter int PHASE_W    = 64,
  parameter int LOG2N      = 3,
  parameter int CNT_W      = 32,
  parameter int NORM_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refTick,
  input  logic [PHASE_W-1:0] nominalInc,
  input  logic [PHASE_W-1:0] initPhase,
  output logic [PHASE_W-1:0] corrInc,
  output logic               corrValid,
  output logic [PHASE_W-1:0] phaseWord
);
  strobeT strb;

  nco_window_ctrl #(.LOG2N(LOG2N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .refTick (refTick),
    .strb    (strb)
  );

  nco_scale_datapath #(
    .PHASE_W    (PHASE_W),
    .CNT_W      (CNT_W),
    .NORM_SHIFT (NORM_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .nominalInc (nominalInc),
    .initPhase  (initPhase),
    .corrInc    (corrInc),
    .corrValid  (corrValid),
    .phaseWord  (phaseWord)
  );
endmodule

// File: tb/tb_nco_drift_scaler.sv
`timescale 1ns/1ps
module tb_nco_drift_scaler;
  localparam int N     = 8;
  localparam int SHIFT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refTick = 1'b0;
  logic [63:0] nominalInc = '0;
  logic [63:0] initPhase = '0;
  logic [63:0] corrInc;
  logic        corrValid;
  logic [63:0] phaseWord;

  nco_drift_scaler #(.PHASE_W(64), .LOG2N(3), .CNT_W(32), .NORM_SHIFT(SHIFT)) dut (
    .clk(clk), .rst(rst), .refTick(refTick), .nominalInc(nominalInc),
    .initPhase(initPhase), .corrInc(corrInc), .corrValid(corrValid),
    .phaseWord(phaseWord)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] prevPhase, edgeInc, curInc, nextInc, expCorr;
  string edgeTag;
  bit applyNext, haveNew;
  int tickIdx, sinceNth, capCalls, validCount;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // One local cycle: sample at negedge, check, then drive the next inputs
  task automatic stepCycle(input bit tickNow);
    logic [127:0] full;
    @(negedge clk);
    sinceNth++;
    capCalls++;
    chk(phaseWord === prevPhase + edgeInc, edgeTag, "phase step", phaseWord, prevPhase + edgeInc); // R2
    if (sinceNth == 2) begin
      chk(corrValid === 1'b1, "R7", "valid two cycles after closing tick", 64'(corrValid), 64'd1);
      chk(corrInc === expCorr, "R6", "scaled increment (R4 count)", corrInc, expCorr);
      validCount++;
    end else begin
      chk(corrValid === 1'b0, "R5", "no valid off window end", 64'(corrValid), 64'd0);
    end
    prevPhase = phaseWord;
    if (applyNext) begin
      curInc = nextInc;
      applyNext = 1'b0;
      haveNew = 1'b1;
    end
    if (corrValid === 1'b1) begin
      nextInc = corrInc;
      applyNext = 1'b1;
    end
    edgeInc = haveNew ? curInc : nominalInc;
    edgeTag = haveNew ? "R8" : "R3";
    if (tickNow) begin
      if (tickIdx == N - 1) begin
        full = 128'(capCalls) * {64'd0, nominalInc};
        expCorr = full[SHIFT+63:SHIFT];
        sinceNth = 0;
        capCalls = 0;
      end
      tickIdx = (tickIdx + 1) % N;
    end
    refTick = tickNow;
  endtask

  task automatic setNominal(input logic [63:0] nom);
    nominalInc = nom;
    if (!haveNew) edgeInc = nom;
  endtask

  task automatic doReset(input logic [63:0] init, input logic [63:0] nom);
    @(negedge clk);
    rst = 1'b1;
    refTick = 1'b0;
    initPhase = init;
    nominalInc = nom;
    @(negedge clk);
    @(negedge clk);
    chk(phaseWord === init, "R1", "phase in reset", phaseWord, init);
    chk(corrValid === 1'b0, "R1", "valid in reset", 64'(corrValid), 64'd0);
    chk(corrInc === 64'd0, "R1", "corrInc in reset", corrInc, 64'd0);
    rst = 1'b0;
    prevPhase = init;
    edgeInc = nom;
    edgeTag = "R3";
    haveNew = 1'b0;
    applyNext = 1'b0;
    tickIdx = 0;
    sinceNth = 100;
    capCalls = 0;
  endtask

  task automatic testNominalRun(input int cycles);
    logic [63:0] start;
    start = phaseWord;
    for (int i = 0; i < cycles; i++) stepCycle(1'b0);
    chk(phaseWord === start + 64'(cycles) * nominalInc, "R3", "nominal run total",
        phaseWord, start + 64'(cycles) * nominalInc);
  endtask

  task automatic testWindows(input int gapA, input int gapB, input int nWin,
                             input logic [63:0] nom);
    setNominal(nom);
    validCount = 0;
    for (int w = 0; w < nWin; w++) begin
      for (int t = 0; t < N; t++) begin
        int gap;
        gap = (t % 2 == 0) ? gapA : gapB;
        stepCycle(1'b1);
        for (int g = 1; g < gap; g++) stepCycle(1'b0);
      end
    end
    for (int i = 0; i < 3; i++) stepCycle(1'b0);
    chk(validCount == nWin, "R5", "valid pulses per window", 64'(validCount), 64'(nWin));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R7 watchdog expired actual=timeout expected=completion");
    printSummary();
    $finish;
  end

  initial begin
    // Reset state and nominal-increment phase (R1, R3)
    doReset(64'h1234_5678_9ABC_DEF0, 64'h0100_0000_0000_0000);
    testNominalRun(12);
    // Ideal ratio: 32 cycles per window gives nominal back (R6)
    testWindows(4, 4, 3, 64'h0100_0000_0000_0000);
    chk(corrInc === 64'h0100_0000_0000_0000, "R6", "ideal window keeps nominal",
        corrInc, 64'h0100_0000_0000_0000);
    // Fast local clock, unequal gaps (R4, R8)
    testWindows(4, 5, 3, 64'h0000_0400_0000_0000);
    // Slow local clock with full-width nominal: product truncation (R6)
    testWindows(3, 3, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    // Irregular spacing (R4)
    testWindows(7, 2, 2, 64'h0123_4567_89AB_CDEF);
    // Second reset: reload near top, wrap, nominal again (R1, R2, R3)
    doReset(64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020);
    stepCycle(1'b0);
    chk(phaseWord === 64'h10, "R2", "accumulator wrap", phaseWord, 64'h10);
    testNominalRun(5);
    testWindows(4, 4, 1, 64'h0000_0000_0000_0020);
    printSummary();
    $finish;
  end
endmodule